// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the N-divider control of an integer-N frequency synthesizer. It is clocked by the output of an external dual-modulus prescaler that divides by P or by P+1. The block holds a swallow count A and a main count B. It drives a modulus-select pin so that the prescaler divides by P+1 for A of its output cycles and by P for the other B-A. One complete N cycle therefore spans P*B + A prescaler input cycles. At the end of each N cycle the block emits a one-cycle feedback pulse for the phase comparator.

The swallow and main values arrive on plain program pins. The counters take new values only at a cycle boundary or while the divider is stopped. There is a counter-reset input and a power-down input. A mode pin decides whether power-down stops the divider at once or only after the current N cycle has finished. Illegal program values raise an error flag and keep the divider stopped with its outputs low. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `swallow_ndiv`

## Requirements
- R1: While A and B are held, consecutive feedback pulses are exactly B clock cycles apart, and modulus-select is high for A of those cycles. With a prescaler of modulus P, the span therefore covers P*B + A input cycles.
- R2: In each N cycle, modulus-select is high in the first A clock cycles and low in the remaining B-A cycles. When A=0 it never rises.
- R3: The feedback pulse is high for exactly one clock cycle, the last cycle of each N cycle.
- R4: The counters take the program pins in the cycle of a feedback pulse, and in every cycle while stopped. A program change in the middle of an N cycle does not alter that cycle.
- R5: While the counter reset is high, the divider is stopped from the next clock edge: `active`, `mod_hi` and `fb_pulse` are low. After the reset is released, the first active cycle is the first cycle of a fresh N cycle.
- R6: With `pd_sync`=0, a high `pwr_dn` stops the divider from the next clock edge and keeps it stopped while held.
- R7: With `pd_sync`=1, a high `pwr_dn` in a running cycle is stored. The current N cycle still completes with its feedback pulse, and the divider stops from the next edge. This holds even if `pwr_dn` falls before that boundary.
- R8: `prog_err` is high exactly when B < 3 or B < A + B_MARGIN (B_MARGIN=0 by default). If the values are illegal at a boundary, or while stopped, the divider stays stopped. It restarts from the first cycle of a fresh N cycle once the values are legal.
- R9: While `rst_n` is low, `active`, `mod_hi` and `fb_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| a_prog | input | A_W | Swallow count A |
| b_prog | input | B_W | Main count B |
| cnt_rst | input | 1 | Counter reset, holds the divider stopped |
| pwr_dn | input | 1 | Power-down request |
| pd_sync | input | 1 | 1: power-down at the next boundary, 0: immediate |
| mod_hi | output | 1 | Modulus select, 1 selects divide by P+1 |
| fb_pulse | output | 1 | One-cycle feedback pulse per N cycle |
| active | output | 1 | Divider running |
| prog_err | output | 1 | Program values violate the legality rules |

## Verification
Two events can fall in the same cycle: a synchronous power-down request and the feedback pulse that ends a cycle. A program change can likewise land on a boundary. The bench waits until it sees the feedback pulse and then raises `pwr_dn` or changes A/B inside that same cycle. It then checks that the divider stops, or takes the new values, at the very next edge and not one N cycle later. Every output is compared on every clock against a behavioural model that counts position within the N cycle upward. That model is built independently of the down-counting RTL.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/swdiv_legal.sv
module swdiv_legal #(
  parameter int A_W      = 3,
  parameter int B_W      = 12,
  parameter int B_MIN    = 3,
  parameter int B_MARGIN = 0
) (
  input  logic [A_W-1:0] a_val,
  input  logic [B_W-1:0] b_val,
  output logic           ok
);
  localparam int CW = ((A_W > B_W) ? A_W : B_W) + 2;

  logic [CW-1:0] a_need;
  logic [CW-1:0] b_ext;

  always_comb begin
    a_need = CW'(a_val) + CW'(B_MARGIN);
    b_ext  = CW'(b_val);
    ok     = (b_ext >= CW'(B_MIN)) && (b_ext >= a_need);
  end
endmodule

// File: rtl/swdiv_cnt.sv
module swdiv_cnt #(
  parameter int A_W = 3,
  parameter int B_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [A_W-1:0] a_val,
  input  logic [B_W-1:0] b_val,
  output logic           swallow,
  output logic           last
);
  logic [A_W-1:0] a_rem;
  logic [B_W-1:0] b_rem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_rem <= '0;
      b_rem <= '0;
    end else if (load) begin
      a_rem <= a_val;
      b_rem <= b_val - B_W'(1);
    end else begin
      if (b_rem != '0) b_rem <= b_rem - B_W'(1);
      if (a_rem != '0) a_rem <= a_rem - A_W'(1);
    end
  end

  assign swallow = (a_rem != '0);
  assign last    = (b_rem == '0);
endmodule

// File: rtl/swdiv_ctrl.sv
module swdiv_ctrl
  import swdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_rst,
  input  logic pwr_dn,
  input  logic pd_sync,
  input  logic prog_ok,
  input  logic last,
  output logic run,
  output logic load
);
  div_state_e state_q, state_d;
  logic       pend_q, pend_d;
  logic       pd_now, pd_later;

  assign pd_now   = pwr_dn && !pd_sync;
  assign pd_later = pwr_dn &&  pd_sync;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    unique case (state_q)
      DIV_IDLE: begin
        pend_d = 1'b0;
        if (!cnt_rst && !pwr_dn && prog_ok) state_d = DIV_RUN;
      end
      DIV_RUN: begin
        if (cnt_rst || pd_now) begin
          state_d = DIV_IDLE;
          pend_d  = 1'b0;
        end else if (last) begin
          if (pend_q || pd_later || !prog_ok) begin
            state_d = DIV_IDLE;
            pend_d  = 1'b0;
          end
        end else begin
          pend_d = pend_q || pd_later;
        end
      end
      default: state_d = DIV_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= DIV_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign run  = (state_q == DIV_RUN);
  assign load = !run || last;
endmodule

// File: rtl/swallow_ndiv.sv
module swallow_ndiv #(
  parameter int A_W      = 3,
  parameter int B_W      = 12,
  parameter int B_MIN    = 3,
  parameter int B_MARGIN = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [A_W-1:0] a_prog,
  input  logic [B_W-1:0] b_prog,
  input  logic           cnt_rst,
  input  logic           pwr_dn,
  input  logic           pd_sync,
  output logic           mod_hi,
  output logic           fb_pulse,
  output logic           active,
  output logic           prog_err
);
  logic prog_ok;
  logic load;
  logic run;
  logic swallow;
  logic last;

  swdiv_legal #(
    .A_W(A_W), .B_W(B_W), .B_MIN(B_MIN), .B_MARGIN(B_MARGIN)
  ) u_legal (
    .a_val(a_prog),
    .b_val(b_prog),
    .ok   (prog_ok)
  );

  swdiv_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_rst(cnt_rst),
    .pwr_dn (pwr_dn),
    .pd_sync(pd_sync),
    .prog_ok(prog_ok),
    .last   (last),
    .run    (run),
    .load   (load)
  );

  swdiv_cnt #(.A_W(A_W), .B_W(B_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .a_val  (a_prog),
    .b_val  (b_prog),
    .swallow(swallow),
    .last   (last)
  );

  assign mod_hi   = run && swallow;
  assign fb_pulse = run && last;
  assign active   = run;
  assign prog_err = !prog_ok;
endmodule

// File: rtl/swallow_ndiv_chk.sv
module swallow_ndiv_chk (
  input logic clk,
  input logic rst_n,
  input logic cnt_rst,
  input logic pwr_dn,
  input logic pd_sync,
  input logic mod_hi,
  input logic fb_pulse,
  input logic active,
  input logic prog_err
);
  AST_FB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse); // R3

  AST_CRST_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |=> !active); // R5

  AST_ASYNC_PD: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn && !pd_sync) |=> !active); // R6

  AST_SYNC_PD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && fb_pulse && pwr_dn && pd_sync) |=> !active); // R7

  AST_ERR_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_pulse && prog_err) |=> !active); // R8

  AST_ERR_NOSTART: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && prog_err) |=> !active); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!mod_hi && !fb_pulse)); // R8
endmodule

bind swallow_ndiv swallow_ndiv_chk u_chk (.*);

// File: tb/swallow_ndiv_tb.sv
`timescale 1ns/1ps
module swallow_ndiv_tb;
  localparam int A_W = 3;
  localparam int B_W = 12;
  localparam int P   = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [A_W-1:0] a_prog = '0;
  logic [B_W-1:0] b_prog = 12'd7;
  logic           cnt_rst = 1'b0;
  logic           pwr_dn = 1'b0;
  logic           pd_sync = 1'b0;
  logic           mod_hi, fb_pulse, active, prog_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  swallow_ndiv u_dut (
    .clk(clk), .rst_n(rst_n), .a_prog(a_prog), .b_prog(b_prog),
    .cnt_rst(cnt_rst), .pwr_dn(pwr_dn), .pd_sync(pd_sync),
    .mod_hi(mod_hi), .fb_pulse(fb_pulse), .active(active), .prog_err(prog_err)
  );

  // behavioural model: position counts upward through the N cycle
  bit m_run = 0;
  bit m_pend = 0;
  int m_pos = 0;
  int m_a = 0;
  int m_b = 0;

  function automatic bit legal(int a, int b);
    return (b >= 3) && (b >= a);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_pend = 0; m_pos = 0;
    end else if (!m_run) begin
      m_a = a_prog; m_b = b_prog; m_pos = 0; m_pend = 0;
      if (!cnt_rst && !pwr_dn && legal(a_prog, b_prog)) m_run = 1;
    end else if (cnt_rst || (pwr_dn && !pd_sync)) begin
      m_run = 0; m_pend = 0;
    end else if (m_pos == m_b - 1) begin
      m_a = a_prog; m_b = b_prog; m_pos = 0;
      if (m_pend || (pwr_dn && pd_sync) || !legal(a_prog, b_prog)) begin
        m_run = 0; m_pend = 0;
      end
    end else begin
      m_pos++;
      if (pwr_dn && pd_sync) m_pend = 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ratio tracking across spans
  bit span_ok = 0;
  bit dirty = 0;
  int per_cnt = 0;
  int mod_cnt = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 mod_hi", mod_hi, (m_run && m_pos < m_a) ? 1 : 0);
      chk("R3 R4 fb_pulse", fb_pulse, (m_run && m_pos == m_b - 1) ? 1 : 0);
      chk("R5/R6/R7 active", active, m_run);
      chk("R8 prog_err", prog_err, legal(a_prog, b_prog) ? 0 : 1);
      if (active) begin
        per_cnt++;
        if (mod_hi) mod_cnt++;
        if (fb_pulse) begin
          if (span_ok && !dirty) begin
            chk("R1 period", per_cnt, int'(b_prog));
            chk("R1 swallow", mod_cnt, int'(a_prog));
            chk("R1 ratio", P * per_cnt + mod_cnt, P * int'(b_prog) + int'(a_prog));
          end
          span_ok = 1; dirty = 0; per_cnt = 0; mod_cnt = 0;
        end
      end else begin
        span_ok = 0; per_cnt = 0; mod_cnt = 0;
      end
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_prog(int a, int b);
    a_prog = A_W'(a); b_prog = B_W'(b); dirty = 1;
  endtask

  task automatic wait_fb();
    do @(negedge clk); while (!fb_pulse);
    #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    run(4);
    // R9 reset state
    chk("R9 active", active, 0);
    chk("R9 mod_hi", mod_hi, 0);
    chk("R9 fb_pulse", fb_pulse, 0);
    rst_n = 1'b1;
    set_prog(3, 7);
    run(40);
    set_prog(0, 9);                      // R2 A=0
    run(40);
    set_prog(7, 7);                      // A=B corner
    run(30);
    set_prog(2, 3);                      // minimum B
    run(20);
    set_prog(5, 10);
    run(25);
    wait_fb(); run(3);
    set_prog(1, 5);                      // R4 mid-cycle change
    run(30);
    wait_fb();
    set_prog(4, 6);                      // R4 change in boundary cycle
    run(30);
    run(3); cnt_rst = 1; run(5); cnt_rst = 0;   // R5
    run(30);
    run(2); pd_sync = 0; pwr_dn = 1; run(6); pwr_dn = 0;  // R6
    run(25);
    pd_sync = 1;
    wait_fb(); run(2); pwr_dn = 1; run(1); pwr_dn = 0;    // R7 dropped early
    run(20);
    wait_fb(); pwr_dn = 1; run(4); pwr_dn = 0;            // R7 coincident
    run(20);
    set_prog(1, 2);                      // R8 illegal B
    run(20);
    set_prog(5, 4);                      // R8 A > B
    run(15);
    set_prog(3, 8);
    run(40);
    wait_fb(); set_prog(6, 5);           // R8 illegal at boundary
    run(10);
    set_prog(2, 4);
    run(20);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule